// File: doc/BRIEF.md
# Pin Change Notification Controller

This block watches a set of general-purpose input pins (21 by default) and raises a level interrupt request whenever a pin whose notification is enabled changes level, in either direction. Each pin is first passed through a two-flop synchronizer. The synchronized value is then compared with a stored copy of the previous sample. Any difference on an enabled pin sets a sticky flag. The flag stays set until software pulses the clear input.

Software programs the block through a small register port. Per-pin notification enables and per-pin weak pull-up requests are each split over two 16-bit words: a low word for pins 0 to 15 and a high word for pins 16 to 20. The pull-up requests leave the block as control bits for the pad ring. A request is forced off whenever the pad reports that the pin is driven as an output. An optional wake output compares the raw pin levels with the stored samples using gates only, so it can signal a change while the clock is stopped.

Top module: `pin_change_notifier`

## Requirements
- R1: After reset, `irq` and `wake` are 0, `pullup_en` is all zeros, and every register address reads 0.
- R2: Register address 0 holds the notification enables of pins 0..15 in data bits 15:0. Address 1 holds pins 16..20 in bits 4:0, and its bits 15:5 read 0. Addresses 2 and 3 hold the pull-up requests with the same split. Reads are combinational from `reg_addr`. Writes take effect at the rising edge where `reg_we` is 1.
- R3: A rising or falling level change on an enabled pin that is stable before clock edge k sets `irq` at edge k+2. `irq` is still 0 after edge k+1.
- R4: A level change on a pin whose enable bit is 0 never sets `irq`.
- R5: Once set, `irq` stays 1 until `flag_clr` is 1 at a rising edge. If no change is detected at that edge, `irq` is 0 after it.
- R6: When a detected change and `flag_clr` meet at the same edge, `irq` is 1 after that edge.
- R7: A pin that changed level while disabled does not set `irq` when it is enabled later.
- R8: `pullup_en[i]` equals the pull-up request bit of pin i AND `pin_is_input[i]`.
- R9: `wake` is 1, with no clock edge needed, while any enabled pin's raw level differs from its stored previous sample. It returns to 0 once that level has been captured (by edge k+2 for a change before edge k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| pin_in | input | 21 | Raw pin levels |
| pin_is_input | input | 21 | 1 when the pin is configured as an input |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky change-notification request |
| wake | output | 1 | Clockless change indication |
| pullup_en | output | 21 | Gated weak pull-up controls |

## Verification
The assertions are checked on every cycle for four properties:
- no pull-up is active on an output pin;
- a set flag holds until it is cleared;
- every rising edge of the flag traces back to a pin level change three samples earlier;
- a clear with no change in flight empties the flag.

The remaining behaviours need the bench's scenarios, because they depend on register contents that are not visible at the ports:
- the exact set latency per pin for both directions;
- silence on disabled pins;
- the change-plus-clear collision;
- the absence of a false trigger after a late enable;
- the clockless assertion of `wake`.

// File: rtl/cn_pkg.sv
package cn_pkg;
   typedef enum logic [1:0] {
      ADR_EN_LO = 2'd0,
      ADR_EN_HI = 2'd1,
      ADR_PU_LO = 2'd2,
      ADR_PU_HI = 2'd3
   } cn_addr_e;
endpackage

// File: rtl/cn_sync.sv
module cn_sync #(
   parameter int WIDTH  = 21,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar st = 0; st < STAGES; st++) begin : g_stage
      if (st == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[st] <= '0;
            else        chain[st] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[st] <= '0;
            else        chain[st] <= chain[st-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cn_regs.sv
module cn_regs
   import cn_pkg::*;
#(
   parameter int NUM_PINS = 21,
   parameter int DATA_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic [NUM_PINS-1:0] en,
   output logic [NUM_PINS-1:0] pu
);
   localparam int LO_PINS = DATA_W;
   localparam int HI_PINS = NUM_PINS - LO_PINS;

   logic [NUM_PINS-1:0] en_q, pu_q;
   cn_addr_e            sel;

   assign sel = cn_addr_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         pu_q <= '0;
      end else if (we) begin
         case (sel)
            ADR_EN_LO: en_q[LO_PINS-1:0]        <= wdata[LO_PINS-1:0];
            ADR_EN_HI: en_q[NUM_PINS-1:LO_PINS] <= wdata[HI_PINS-1:0];
            ADR_PU_LO: pu_q[LO_PINS-1:0]        <= wdata[LO_PINS-1:0];
            default:   pu_q[NUM_PINS-1:LO_PINS] <= wdata[HI_PINS-1:0];
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         ADR_EN_LO: rdata[LO_PINS-1:0] = en_q[LO_PINS-1:0];
         ADR_EN_HI: rdata[HI_PINS-1:0] = en_q[NUM_PINS-1:LO_PINS];
         ADR_PU_LO: rdata[LO_PINS-1:0] = pu_q[LO_PINS-1:0];
         default:   rdata[HI_PINS-1:0] = pu_q[NUM_PINS-1:LO_PINS];
      endcase
   end

   assign en = en_q;
   assign pu = pu_q;
endmodule

// File: rtl/cn_detect.sv
module cn_detect #(
   parameter int NUM_PINS = 21,
   parameter bit WAKE_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] raw,
   input  logic [NUM_PINS-1:0] synced,
   input  logic [NUM_PINS-1:0] en,
   input  logic                clr,
   output logic                flag,
   output logic                wake
);
   logic [NUM_PINS-1:0] prev_q;
   logic                flag_q;
   logic                hit;

   // The previous sample tracks every pin, enabled or not.
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;

   assign hit = |((synced ^ prev_q) & en);

   // A set request has priority over a clear.
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   flag_q <= 1'b0;
      else if (hit) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

   assign flag = flag_q;

   if (WAKE_EN) begin : g_wake
      assign wake = |((raw ^ prev_q) & en);
   end else begin : g_no_wake
      assign wake = 1'b0;
   end
endmodule

// File: rtl/pin_change_notifier.sv
module pin_change_notifier #(
   parameter int NUM_PINS    = 21,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit WAKE_EN     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [1:0]          reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] pin_is_input,
   input  logic                flag_clr,
   output logic                irq,
   output logic                wake,
   output logic [NUM_PINS-1:0] pullup_en
);
   if (NUM_PINS <= DATA_W || NUM_PINS > 2 * DATA_W) begin : g_bad_pins
      $error("NUM_PINS must span both register words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] synced, en, pu;

   cn_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(synced));

   cn_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .en(en), .pu(pu));

   cn_detect #(.NUM_PINS(NUM_PINS), .WAKE_EN(WAKE_EN)) u_detect (
      .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(synced), .en(en),
      .clr(flag_clr), .flag(irq), .wake(wake));

   assign pullup_en = pu & pin_is_input;
endmodule

// File: rtl/cn_checker.sv
module cn_checker #(
   parameter int NUM_PINS = 21
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] pin_is_input,
   input logic                flag_clr,
   input logic                irq,
   input logic [NUM_PINS-1:0] pullup_en
);
   AST_PULLUP_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pullup_en & ~pin_is_input) == '0); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !flag_clr |=> irq); // R5

   AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(pin_in, 3) != $past(pin_in, 4)); // R3

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && $past(pin_in, 2) == $past(pin_in, 3) |=> !irq); // R5
endmodule

bind pin_change_notifier cn_checker #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_is_input(pin_is_input),
   .flag_clr(flag_clr), .irq(irq), .pullup_en(pullup_en));

// File: tb/test_pin_change_notifier.sv
module test_pin_change_notifier;
   localparam int N = 21;

   logic          clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, flag_clr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0, reg_rdata;
   logic [N-1:0]  pin_in = '0, pin_is_input = '0, pullup_en;
   logic          irq, wake;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   pin_change_notifier i_pin_change_notifier (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_is_input(pin_is_input), .flag_clr(flag_clr), .irq(irq),
      .wake(wake), .pullup_en(pullup_en));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      cyc(1);
      reg_we = 1'b0;
   endtask

   task automatic rd(string req, logic [1:0] a, logic [15:0] exp);
      reg_addr = a; #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic set_en(logic [N-1:0] m);
      wr(2'd0, m[15:0]);
      wr(2'd1, {11'b0, m[20:16]});
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
   endtask

   initial begin
      #(10 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      cyc(2);
      // R1: state held in reset and just after it
      chk("R1 irq", irq, 0);
      chk("R1 wake", wake, 0);
      chk("R1 pullup", pullup_en, 0);
      rst_n = 1'b1;
      cyc(1);
      for (int a = 0; a < 4; a++) rd("R1 regs", a[1:0], 16'h0);

      // R3/R4/R5/R9: one enabled pin at a time, both directions
      for (int p = 0; p < N; p++) begin
         for (int dir = 0; dir < 2; dir++) begin
            set_en(N'(1) << p);
            rd("R2 en readback", (p < 16) ? 2'd0 : 2'd1,
               (p < 16) ? 16'(1 << p) : 16'(1 << (p - 16)));
            pin_in[p] = ~pin_in[p];
            #1 chk("R9 wake without clock", wake, 1);
            cyc(2);
            chk("R3 not yet set", irq, 0);
            cyc(1);
            chk("R3 set after latency", irq, 1);
            chk("R9 wake drops", wake, 0);
            cyc(3);
            chk("R5 held", irq, 1);
            clear_flag();
            chk("R5 cleared", irq, 0);
            // R4: a neighbour that is disabled
            pin_in[(p + 1) % N] = ~pin_in[(p + 1) % N];
            #1 chk("R4 no wake", wake, 0);
            cyc(4);
            chk("R4 disabled pin ignored", irq, 0);
         end
      end

      // R7: a change while disabled, then a later enable
      set_en('0);
      pin_in[3] = ~pin_in[3];
      cyc(4);
      set_en(N'(1) << 3);
      cyc(4);
      chk("R7 no false trigger", irq, 0);

      // R6: the change and the clear meet at the same edge
      pin_in[3] = ~pin_in[3];
      cyc(2);
      chk("R6 pre", irq, 0);
      flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
      chk("R6 set wins", irq, 1);
      clear_flag();
      chk("R6 clears after", irq, 0);

      // R8 and R2: pull-up gating and readback sweep
      for (int i = 0; i < 64; i++) begin
         logic [N-1:0] pu, dirv;
         pu   = N'((i * 32'h0002_F1B3) ^ (i << 9));
         dirv = N'((i * 32'h0001_3579) ^ 32'h0015_A5A5);
         wr(2'd2, pu[15:0]);
         wr(2'd3, {11'b0, pu[20:16]});
         pin_is_input = dirv;
         #1 chk("R8 gated pull-up", pullup_en, pu & dirv);
         rd("R2 pu lo", 2'd2, pu[15:0]);
         rd("R2 pu hi", 2'd3, {11'b0, pu[20:16]});
      end
      wr(2'd1, 16'hFFFF);
      rd("R2 hi upper bits zero", 2'd1, 16'h001F);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule